// File: doc/BRIEF.md
# Crank-Angle Pulse Capture

This block measures a digital pulse driven by an engine controller, such as a fuel-injector command or an ignition-coil dwell, against the crank angle of a simulated engine. The pulse line is asynchronous to the capture clock. It passes through a two-flop synchronizer, and the edges are found on the synchronized level. When the pulse rises, the block records the current adjusted crank angle and restarts a tick counter. When the pulse falls, it records the end angle. It then publishes the start angle, the end angle, the angular span and the elapsed tick count together, and raises a valid flag.

The angle bus carries unsigned integers in fixed units. `CYCLE_UNITS` units make one crank revolution, and the default of 3600 gives a resolution of 0.1 degree. In two-stroke mode the bus runs from 0 to `CYCLE_UNITS-1`. In four-stroke mode it runs from 0 to `2*CYCLE_UNITS-1`. The span is computed so that it stays correct when a pulse crosses the wrap point of the cycle. A host reads the result registers and then pulses the acknowledge input to clear the flag.

Top module: `angle_pulse_capture`

## Requirements
- R1: After reset, `valid` is 0 and `start_angle`, `end_angle`, `span_angle` and `tick_count` are all 0.
- R2: `pulse_in` is synchronized by two flops. If `pulse_in` falls before clock edge k, `valid` is still 0 after edge k+1 and is 1 after edge k+2.
- R3: `start_angle` holds the value of `angle_in` sampled at the clock edge where the synchronized rising edge is registered. For `pulse_in` rising before edge k, that is edge k+2.
- R4: `end_angle` holds the value of `angle_in` sampled at the clock edge where the synchronized falling edge is registered. For `pulse_in` falling before edge k, that is edge k+2.
- R5: In two-stroke mode (`four_stroke`=0), `span_angle` = `end_angle` - `start_angle` when `end_angle` >= `start_angle`. Otherwise it is `end_angle` + `CYCLE_UNITS` - `start_angle`.
- R6: In four-stroke mode (`four_stroke`=1), angles up to `2*CYCLE_UNITS-1` are accepted, and a wrapped span adds `2*CYCLE_UNITS`. The span is always below `2*CYCLE_UNITS`.
- R7: `tick_count` equals the number of clock cycles for which `pulse_in` was high.
- R8: The tick count saturates at `2^TICK_W-1` and does not wrap.
- R9: `valid` is set on a captured falling edge. It clears on the clock edge after `ack` is sampled high, unless a new falling edge is captured in the same cycle.
- R10: The four result outputs change only on a captured falling edge. A rising edge, a pulse still in progress and `ack` all leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_in | input | 1 | Asynchronous pulse line from the engine controller |
| angle_in | input | ANGLE_W | Live adjusted crank angle in units |
| four_stroke | input | 1 | 1: cycle is 2*CYCLE_UNITS; 0: cycle is CYCLE_UNITS |
| ack | input | 1 | Host acknowledge; clears `valid` |
| valid | output | 1 | New result available |
| start_angle | output | ANGLE_W | Angle latched at the rising edge |
| end_angle | output | ANGLE_W | Angle latched at the falling edge |
| span_angle | output | ANGLE_W | Wrap-aware angular duration |
| tick_count | output | TICK_W | Pulse duration in clock ticks, saturating |

## Verification
Directed pulses cover the span arithmetic in four cases:
- a span without a wrap;
- a span across the 360-degree wrap in two-stroke mode;
- a span across the 720-degree wrap in four-stroke mode, and an end angle above 360 degrees;
- equal start and end angles.

Together these separate the plain subtraction from the added cycle length, and show whether that length depends on the mode. A pulse longer than the counter's range tells saturation apart from wrapping. While it is still high, the bench confirms that an earlier result survives a rising edge and an acknowledge. Random pulses with random angles, lengths and modes then run against a modulo-based reference span. The angle bus is moved in the middle of each pulse, so a capture taken at the wrong time shows up in the latched angles.

// File: rtl/apc_pkg.sv
package apc_pkg;

  // Angular distance from a0 forward to a1 on a cycle of length cyc.
  function automatic logic [31:0] wrap_span(input logic [31:0] a0,
                                            input logic [31:0] a1,
                                            input logic [31:0] cyc);
    logic [31:0] r;
    if (a1 >= a0) r = a1 - a0;
    else          r = (a1 + cyc) - a0;
    return r;
  endfunction

  // Increment that sticks at lim.
  function automatic logic [31:0] sat_inc(input logic [31:0] v,
                                          input logic [31:0] lim);
    logic [31:0] r;
    if (v >= lim) r = lim;
    else          r = v + 32'd1;
    return r;
  endfunction

endpackage

// File: rtl/apc_sync_edge.sv
module apc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_async};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  AST_EDGE_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> $past(sync_q[STAGES-1]) && !sync_q[STAGES-1]);  // R2
endmodule

// File: rtl/apc_tick_counter.sv
module apc_tick_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         run,
  output logic [W-1:0] count
);
  import apc_pkg::*;
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (start) count <= W'(1);
    else if (run)   count <= W'(sat_inc(32'(count), 32'(MAX)));
  end

  AST_TICK_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    run && !start && count == MAX |=> count == MAX);  // R8
  AST_TICK_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    run && !start |=> count >= $past(count));  // R7
endmodule

// File: rtl/apc_result_bank.sv
module apc_result_bank #(
  parameter int AW = 13,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          ack,
  input  logic [AW-1:0] start_d,
  input  logic [AW-1:0] end_d,
  input  logic [AW-1:0] span_d,
  input  logic [TW-1:0] ticks_d,
  output logic          valid,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] end_q,
  output logic [AW-1:0] span_q,
  output logic [TW-1:0] ticks_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      span_q  <= '0;
      ticks_q <= '0;
    end else if (capture) begin
      start_q <= start_d;
      end_q   <= end_d;
      span_q  <= span_d;
      ticks_q <= ticks_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid <= 1'b0;
    else if (capture) valid <= 1'b1;
    else if (ack)     valid <= 1'b0;
  end

  AST_VALID_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> valid);  // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !capture |=> !valid);  // R9
  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(start_q) && $stable(end_q) && $stable(span_q) && $stable(ticks_q));  // R10
endmodule

// File: rtl/angle_pulse_capture.sv
module angle_pulse_capture #(
  parameter int ANGLE_W     = 13,
  parameter int CYCLE_UNITS = 3600,
  parameter int TICK_W      = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pulse_in,
  input  logic [ANGLE_W-1:0] angle_in,
  input  logic               four_stroke,
  input  logic               ack,
  output logic               valid,
  output logic [ANGLE_W-1:0] start_angle,
  output logic [ANGLE_W-1:0] end_angle,
  output logic [ANGLE_W-1:0] span_angle,
  output logic [TICK_W-1:0]  tick_count
);
  import apc_pkg::*;
  localparam int CYCLE_4S = 2 * CYCLE_UNITS;

  logic               pulse_lvl;
  logic               rise_evt;
  logic               fall_evt;
  logic [ANGLE_W-1:0] start_hold_q;
  logic [TICK_W-1:0]  ticks_run;
  logic [31:0]        cycle_len;
  logic [ANGLE_W-1:0] span_now;

  apc_sync_edge #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pulse_in),
    .level(pulse_lvl), .rise(rise_evt), .fall(fall_evt)
  );

  apc_tick_counter #(.W(TICK_W)) u_ticks (
    .clk(clk), .rst_n(rst_n), .start(rise_evt), .run(pulse_lvl),
    .count(ticks_run)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        start_hold_q <= '0;
    else if (rise_evt) start_hold_q <= angle_in;
  end

  assign cycle_len = four_stroke ? 32'(CYCLE_4S) : 32'(CYCLE_UNITS);
  assign span_now  = ANGLE_W'(wrap_span(32'(start_hold_q), 32'(angle_in), cycle_len));

  apc_result_bank #(.AW(ANGLE_W), .TW(TICK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .capture(fall_evt), .ack(ack),
    .start_d(start_hold_q), .end_d(angle_in), .span_d(span_now), .ticks_d(ticks_run),
    .valid(valid), .start_q(start_angle), .end_q(end_angle),
    .span_q(span_angle), .ticks_q(tick_count)
  );

  AST_SPAN_BELOW_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> 32'(span_angle) < 32'(CYCLE_4S));  // R6
  AST_START_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> start_hold_q == $past(angle_in));  // R3
  AST_TICKS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> tick_count != '0);  // R7
  AST_END_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> end_angle == $past(angle_in));  // R4
endmodule

// File: tb/angle_pulse_capture_tb_top.sv
module angle_pulse_capture_tb_top;
  localparam int AW  = 13;
  localparam int CU  = 3600;
  localparam int TW  = 12;
  localparam int TMAX = (1 << TW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b0;
  logic [AW-1:0] angle_in = '0;
  logic four_stroke = 1'b0;
  logic ack = 1'b0;
  logic valid;
  logic [AW-1:0] start_angle, end_angle, span_angle;
  logic [TW-1:0] tick_count;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  angle_pulse_capture #(.ANGLE_W(AW), .CYCLE_UNITS(CU), .TICK_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .angle_in(angle_in),
    .four_stroke(four_stroke), .ack(ack), .valid(valid),
    .start_angle(start_angle), .end_angle(end_angle),
    .span_angle(span_angle), .tick_count(tick_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_span(input int sa, input int ea, input bit fs);
    int cyc;
    cyc = fs ? 2 * CU : CU;
    return (ea - sa + cyc) % cyc;
  endfunction

  task automatic host_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R9 valid cleared by ack", int'(valid), 0);
  endtask

  task automatic run_pulse(input int sa, input int ea, input int n, input bit fs,
                           input bit hold_check);
    int ps, pe, psp, pt;
    host_ack();
    ps = int'(start_angle); pe = int'(end_angle);
    psp = int'(span_angle); pt = int'(tick_count);
    four_stroke = fs;
    angle_in = AW'(sa);
    pulse_in = 1'b1;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      if (i == 4) angle_in = AW'($urandom % (fs ? 2 * CU : CU));
      if (i == n - 4) angle_in = AW'(ea);
      if (hold_check && i == n - 2) begin
        chk("R10 start held mid-pulse", int'(start_angle), ps);
        chk("R10 end held mid-pulse", int'(end_angle), pe);
        chk("R10 span held mid-pulse", int'(span_angle), psp);
        chk("R10 ticks held mid-pulse", int'(tick_count), pt);
      end
    end
    @(negedge clk);
    pulse_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 valid not yet after two edges", int'(valid), 0);
    @(negedge clk);
    chk("R2 valid after three edges", int'(valid), 1);
    chk("R3 start angle", int'(start_angle), sa);
    chk("R4 end angle", int'(end_angle), ea);
    chk(fs ? "R6 span four-stroke" : "R5 span two-stroke",
        int'(span_angle), ref_span(sa, ea, fs));
    chk("R7 R8 tick count", int'(tick_count), (n > TMAX) ? TMAX : n);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 valid at reset", int'(valid), 0);
    chk("R1 start at reset", int'(start_angle), 0);
    chk("R1 end at reset", int'(end_angle), 0);
    chk("R1 span at reset", int'(span_angle), 0);
    chk("R1 ticks at reset", int'(tick_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_pulse(100, 900, 10, 1'b0, 1'b0);    // R5 no wrap
    run_pulse(3500, 200, 12, 1'b0, 1'b1);   // R5 wrap at 360
    run_pulse(7000, 150, 9, 1'b1, 1'b1);    // R6 wrap at 720
    run_pulse(1000, 5000, 20, 1'b1, 1'b0);  // R6 end above 360
    run_pulse(2222, 2222, 8, 1'b0, 1'b0);   // R5 zero span
    run_pulse(300, 3000, 5000, 1'b0, 1'b1); // R8 saturation
    // R9: valid persists without ack
    repeat (5) @(negedge clk);
    chk("R9 valid held without ack", int'(valid), 1);

    for (int k = 0; k < 20; k++) begin
      bit fs;
      int cyc;
      fs = 1'($urandom % 2);
      cyc = fs ? 2 * CU : CU;
      run_pulse(int'($urandom % cyc), int'($urandom % cyc),
                8 + int'($urandom % 60), fs, 1'($urandom % 2));
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule